// File: doc/BRIEF.md
# Serial Baud Clock Source Selector

This block produces the clock enables that pace one serial channel. It runs entirely in the oscillator clock domain. A 2-bit source register picks the source. Three choices are fixed divisions of the oscillator clock (by 4, by 8 or by 16). The fourth is a timer underflow strobe, which is halved first. The chosen source gives a full-rate `sample_en` pulse, which a receiver can use to oversample. A further divide-by-16 turns that into the `bit_en` pulse that paces shifting. Every output is a single-cycle enable; the block derives no clocks.

When the channel is a clock-synchronous slave, the source register has no effect. The external serial clock pin is synchronised with two flops. Each rising edge then gives one pulse on both `sample_en` and `bit_en`, with no division. Writing a new value to the source register restarts both divide chains. Leaving slave mode also restarts them. While the oscillator is flagged off, the oscillator-derived sources stay silent.

Top module: `serial_clk_sel`

## Requirements
- R1: Source codes 00, 01 and 10 give one `sample_en` pulse every 16, 8 and 4 clock cycles respectively, while `osc_en` is high and slave mode is off.
- R2: Source code 11 gives one `sample_en` pulse for every second `tmr_uflow` pulse. After a restart, the first underflow of a pair produces no pulse.
- R3: In source 11, `osc_en` has no effect on the output. In sources 00, 01 and 10, `tmr_uflow` has no effect on the output.
- R4: `bit_en` pulses for one cycle in the cycle after every 16th `sample_en` pulse, so its period is 16 times the `sample_en` period.
- R5: After reset the source register holds 00, and both outputs are low. While `osc_en` is low, an oscillator source gives no pulses. The first `sample_en` comes on the N-th clock edge after `osc_en` rises, where N is the selected division.
- R6: With `slave_mode` high, each rising edge of `ext_sclk` gives exactly one cycle with both `sample_en` and `bit_en` high. That cycle follows the second clock edge after the pin rises. The source register and `tmr_uflow` are ignored.
- R7: A write (`sel_we` high) of a value that differs from the source register restarts the chains. The first `sample_en` then comes N cycles after the write cycle, and the first `bit_en` comes 16·N+1 cycles after it. A write of the same value leaves the running phase unchanged.
- R8: With underflows every 4 oscillator clocks and source 11, `bit_en` pulses every 128 clocks, which is 19,200 bit/s from a 2.4576 MHz oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | High when the oscillator is running; gates the oscillator-derived sources |
| sel_we | input | 1 | One-cycle write strobe for the source register |
| sel_wdata | input | 2 | New source code: 00 osc/16, 01 osc/8, 10 osc/4, 11 timer/2 |
| slave_mode | input | 1 | High when the channel is a clock-synchronous slave |
| tmr_uflow | input | 1 | One-cycle timer underflow strobe |
| ext_sclk | input | 1 | External serial clock pin, asynchronous |
| sample_en | output | 1 | Full-rate sampling enable, one cycle wide |
| bit_en | output | 1 | Bit-rate shift enable, one cycle wide |

## Verification
The hardest case to reach is a rewrite of the source register partway through a period. Only the timing of the next pulse shows whether the chains restarted. The bench therefore lines up on a `sample_en` pulse and writes in that same cycle. It then counts the cycles to the next pulse. For a different value the count is a full period. For the same value the count is one cycle shorter. Slave entry and exit are reached the same way, with the pin held low first. This shows that the oscillator path is silenced, before the edges are counted.

// File: rtl/sclk_pkg.sv
// Shared types for the serial baud clock selector.
// Assumes: the source code is a 2-bit field whose encoding is fixed by software.
package sclk_pkg;

    typedef enum logic [1:0] {
        SRC_OSC16 = 2'b00,
        SRC_OSC8  = 2'b01,
        SRC_OSC4  = 2'b10,
        SRC_TMR   = 2'b11
    } src_sel_e;

endpackage

// File: rtl/sclk_prescaler.sv
// Source prescaler: turns the selected source into a one-cycle tick at the
// sampling rate. Oscillator sources count clk cycles gated by osc_en. The
// timer source halves the underflow strobe.
// Assumes: tmr_uflow is a single-cycle strobe in the clk domain; clr restarts
// both the counter and the halving flag.
module sclk_prescaler
    import sclk_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 8,
    parameter int DIV_SLOW = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     osc_en,
    input  src_sel_e src,
    input  logic     uflow,
    output logic     tick
);

    localparam int CNT_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div_term;
    logic             half;

    // Terminal count for the selected oscillator division.
    always_comb begin
        case (src)
            SRC_OSC4: div_term = CNT_W'(DIV_FAST - 1);
            SRC_OSC8: div_term = CNT_W'(DIV_MID - 1);
            default:  div_term = CNT_W'(DIV_SLOW - 1);
        endcase
    end

    // Counter, halving flag and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            half <= 1'b0;
            tick <= 1'b0;
        end else if (src == SRC_TMR) begin
            cnt <= '0;
            if (uflow) begin
                half <= !half;
                tick <= half;
            end else begin
                tick <= 1'b0;
            end
        end else begin
            half <= 1'b0;
            if (!osc_en) begin
                cnt  <= '0;
                tick <= 1'b0;
            end else if (cnt == div_term) begin
                cnt  <= '0;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt + CNT_W'(1);
                tick <= 1'b0;
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_term); // R1

    AST_OSC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_TMR && !osc_en && !clr) |=> !tick); // R5

    AST_TMR_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_TMR && !clr && uflow && !half) |=> !tick); // R2

endmodule

// File: rtl/sclk_bit_div.sv
// Bit divider: emits one bit enable in the cycle after every RATIO-th tick.
// Assumes: tick is a single-cycle pulse; clr restarts the count from zero.
module sclk_bit_div #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_en
);

    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [CNT_W-1:0] cnt;

    // Count ticks and flag the last tick of each group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt    <= '0;
            bit_en <= 1'b0;
        end else if (tick) begin
            if (cnt == CNT_W'(RATIO - 1)) begin
                cnt    <= '0;
                bit_en <= 1'b1;
            end else begin
                cnt    <= cnt + CNT_W'(1);
                bit_en <= 1'b0;
            end
        end else begin
            bit_en <= 1'b0;
        end
    end

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> !bit_en); // R4

endmodule

// File: rtl/sclk_edge_sync.sv
// Edge synchroniser: brings an asynchronous pin into the clk domain through
// STAGES flops and flags each rising edge for one cycle.
// Assumes: the pin stays in each level for at least two clk cycles.
module sclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES:0] sh;

    // Shift the pin through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    // Rising edge seen at the synchroniser output.
    always_comb begin
        rise = sh[STAGES-1] && !sh[STAGES];
    end

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6

endmodule

// File: rtl/serial_clk_sel.sv
// Serial baud clock source selector. It holds the 2-bit source register and
// drives the prescaler and the bit divider. In slave mode it swaps in the
// synchronised external clock edges.
// Assumes: everything is in the oscillator clock domain; a write of a
// different source code, or slave mode, restarts the divide chains.
module serial_clk_sel
    import sclk_pkg::*;
#(
    parameter int DIV_FAST    = 4,
    parameter int DIV_MID     = 8,
    parameter int DIV_SLOW    = 16,
    parameter int BIT_RATIO   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    input  logic       slave_mode,
    input  logic       tmr_uflow,
    input  logic       ext_sclk,
    output logic       sample_en,
    output logic       bit_en
);

    src_sel_e sel_q;
    logic     chain_clr;
    logic     pre_tick;
    logic     div_bit;
    logic     ext_rise;

    // Source register, reset to the slowest oscillator division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SRC_OSC16;
        end else if (sel_we) begin
            sel_q <= src_sel_e'(sel_wdata);
        end
    end

    // Restart the chains on a real source change or while in slave mode.
    always_comb begin
        chain_clr = slave_mode || (sel_we && (sel_wdata != sel_q));
    end

    sclk_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (chain_clr),
        .osc_en (osc_en),
        .src    (sel_q),
        .uflow  (tmr_uflow),
        .tick   (pre_tick)
    );

    sclk_bit_div #(
        .RATIO (BIT_RATIO)
    ) u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (chain_clr),
        .tick   (pre_tick),
        .bit_en (div_bit)
    );

    sclk_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_sclk),
        .rise  (ext_rise)
    );

    // Output select: external edges in slave mode, divided chain otherwise.
    always_comb begin
        if (slave_mode) begin
            sample_en = ext_rise;
            bit_en    = ext_rise;
        end else begin
            sample_en = pre_tick;
            bit_en    = div_bit;
        end
    end

    AST_BIT_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && bit_en) |-> $past(sample_en)); // R4

    AST_SEL_CHANGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && (sel_wdata != sel_q) && !slave_mode)
            |=> (slave_mode || (!sample_en && !bit_en))); // R7

endmodule

// File: tb/tb_serial_clk_sel.sv
`timescale 1ns/1ps
module tb_serial_clk_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       slave_mode = 1'b0;
    logic       tmr_uflow = 1'b0;
    logic       ext_sclk = 1'b0;
    logic       sample_en;
    logic       bit_en;

    logic       tmr_run = 1'b0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    serial_clk_sel dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_en     (osc_en),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .slave_mode (slave_mode),
        .tmr_uflow  (tmr_uflow),
        .ext_sclk   (ext_sclk),
        .sample_en  (sample_en),
        .bit_en     (bit_en)
    );

    initial forever #2.5 clk = ~clk;

    // Timer model: one underflow strobe every 4 clocks while running.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (tmr_run) begin
                tmr_uflow = (ph == 3);
                ph = (ph == 3) ? 0 : ph + 1;
            end else begin
                tmr_uflow = 1'b0;
                ph = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until the chosen output is high (1 = bit_en).
    task automatic wait_pulse(input bit which, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(which ? bit_en : sample_en) && n < limit);
    endtask

    // Write the source register; caller is at a negedge.
    task automatic write_sel(input logic [1:0] v);
        sel_we = 1'b1;
        sel_wdata = v;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic count_pulses(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_en || bit_en) cnt++;
        end
    endtask

    task automatic t_reset();
        int n;
        repeat (4) @(negedge clk);
        check(!sample_en && !bit_en, "R5 outputs low in reset", int'(sample_en | bit_en), 0);
        rst_n = 1'b1;
        count_pulses(40, n);
        check(n == 0, "R5 no pulses with oscillator off", n, 0);
        osc_en = 1'b1;
        wait_pulse(1'b0, 100, n);
        check(n == 16, "R5 first pulse after enable, default osc/16", n, 16);
        wait_pulse(1'b0, 100, n);
        check(n == 16, "R1 default osc/16 period", n, 16);
    endtask

    task automatic t_osc_div(input logic [1:0] code, input int div);
        int n;
        @(negedge clk);
        write_sel(code);
        wait_pulse(1'b0, 200, n);
        check(n == div, "R7 first sample after select change", n, div);
        wait_pulse(1'b0, 200, n);
        check(n == div, "R1 sample period", n, div);
        wait_pulse(1'b1, 600, n);
        wait_pulse(1'b1, 600, n);
        check(n == 16 * div, "R4 bit period", n, 16 * div);
    endtask

    task automatic t_bit_latency();
        int n;
        @(negedge clk);
        write_sel(2'b01);
        @(negedge clk);
        write_sel(2'b10);
        wait_pulse(1'b1, 200, n);
        check(n == 65, "R7 first bit_en after change to osc/4", n, 65);
    endtask

    task automatic t_same_write();
        int n;
        wait_pulse(1'b0, 100, n);
        write_sel(2'b10);
        wait_pulse(1'b0, 100, n);
        check(n == 3, "R7 same-value write keeps phase", n, 3);
        write_sel(2'b01);
        wait_pulse(1'b0, 100, n);
        check(n == 8, "R7 new-value write restarts", n, 8);
        write_sel(2'b10);
        wait_pulse(1'b0, 100, n);
        check(n == 4, "R7 new-value write restarts (osc/4)", n, 4);
    endtask

    task automatic t_timer();
        int n;
        tmr_run = 1'b1;
        @(negedge clk);
        write_sel(2'b11);
        wait_pulse(1'b0, 100, n);
        wait_pulse(1'b0, 100, n);
        check(n == 8, "R2 timer source halves underflows", n, 8);
        wait_pulse(1'b1, 600, n);
        wait_pulse(1'b1, 600, n);
        check(n == 128, "R8 19200 bit/s divide of 128", n, 128);
        osc_en = 1'b0;
        wait_pulse(1'b0, 100, n);
        wait_pulse(1'b0, 100, n);
        check(n == 8, "R3 timer source ignores osc_en", n, 8);
        osc_en = 1'b1;
        write_sel(2'b10);
        wait_pulse(1'b0, 100, n);
        wait_pulse(1'b0, 100, n);
        check(n == 4, "R3 osc/4 ignores underflows", n, 4);
        tmr_run = 1'b0;
    endtask

    task automatic t_slave();
        int n;
        @(negedge clk);
        write_sel(2'b11);
        tmr_run = 1'b1;
        slave_mode = 1'b1;
        ext_sclk = 1'b0;
        count_pulses(30, n);
        check(n == 0, "R6 slave ignores timer and source", n, 0);
        for (int e = 0; e < 4; e++) begin
            ext_sclk = 1'b1;
            if (e == 2) write_sel(2'b10);
            else @(negedge clk);
            @(negedge clk);
            check(sample_en && bit_en, "R6 edge pulse two clocks after pin rise",
                  int'(sample_en) + int'(bit_en), 2);
            @(negedge clk);
            check(!sample_en && !bit_en, "R6 one pulse per edge",
                  int'(sample_en) + int'(bit_en), 0);
            ext_sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        tmr_run = 1'b0;
        write_sel(2'b01);
        slave_mode = 1'b0;
        wait_pulse(1'b0, 100, n);
        check(n == 8, "R6 chain restarts on slave exit", n, 8);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_osc_div(2'b01, 8);
        t_osc_div(2'b10, 4);
        t_osc_div(2'b00, 16);
        t_bit_latency();
        t_same_write();
        t_timer();
        t_slave();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule